// File: doc/BRIEF.md
# Split-Permission Direct-Mapped TLB

This block caches virtual-to-physical page translations in a direct-mapped array. Each slot holds one physical page number and three virtual-page tags: one for data reads, one for data writes and one for instruction fetches. A tag holds a real page number only when the cached page table entry allowed that kind of access. A slot can therefore answer reads while it still misses on writes, without keeping any permission bits beside the tags.

A lookup gives a virtual address and an access kind. In the same cycle the block returns either a hit with the translated physical address, or a miss. The miss serves as the request to an external page-table walker. The walker answers on the refill port with a leaf page table entry for the faulting address. The block checks that entry against the access kind and the current privilege level. It then either writes the slot or reports an access fault for one cycle.

A flush input invalidates every tag of every slot. The page size, address width and slot count are parameters. The defaults are 4 KiB pages, 64-bit addresses and 16 slots.

Top module: `dtlb_split`

## Requirements
- R1: After reset, and in every cycle after a cycle with `flush` high, every lookup misses until a new refill is written.
- R2: The slot used is the virtual page number (address bits 63:12) modulo 16, which is address bits 15:12. The stored tag is the whole virtual page number, so a refill to another page with the same low page bits evicts the older page.
- R3: Access kinds are encoded 0 = load, 1 = store and 2 = fetch; code 3 is never driven. A lookup hits only when the slot's tag for the given kind equals the address's virtual page number.
- R4: A successful refill fills the load, store and fetch tags with the page number only where the effective permission grants read, write or execute respectively. Any other tag is set to all ones, so a read-only page hits for loads and misses for stores and fetches.
- R5: Entry bit 0 is the valid bit. User-mode permissions are bits 2, 3, 4 (read, write, execute), and supervisor-mode permissions are bits 5, 6, 7 in the same order. With `priv_sup` high the supervisor bits are moved onto the user positions before any check; with it low the user bits are used directly.
- R6: A refill faults when its valid bit is clear or its effective permission lacks the bit for its kind. One cycle after the refill, `flt_valid` is high for one cycle with `flt_kind` and `flt_vaddr` equal to the refill's kind and address. The slot is left unchanged. A refill that does not fault raises no fault.
- R7: On a hit, `lk_paddr` is the entry's bits 63:12 followed by the lookup address bits 11:0, in the same cycle. On a miss or when idle it is zero.
- R8: `lk_miss` is high exactly when `lk_valid` is high and there is no hit. `lk_hit` and `lk_miss` are both low when `lk_valid` is low.
- R9: When `flush` and a non-faulting refill occur in the same cycle, the flush wins and the refill is not written.
- R10: A virtual page number of all ones never hits, because it matches the invalid tag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all tags at this edge |
| priv_sup | input | 1 | 1 = supervisor privilege for refill checks |
| lk_valid | input | 1 | Lookup request |
| lk_kind | input | 2 | Lookup access kind (0 load, 1 store, 2 fetch) |
| lk_vaddr | input | 64 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss, refill request |
| lk_paddr | output | 64 | Translated physical address on hit |
| rf_valid | input | 1 | Refill entry present |
| rf_kind | input | 2 | Access kind of the refill |
| rf_vaddr | input | 64 | Virtual address being refilled |
| rf_pte | input | 64 | Leaf page table entry from the walker |
| flt_valid | output | 1 | Access fault pulse |
| flt_kind | output | 2 | Kind of the faulting access |
| flt_vaddr | output | 64 | Virtual address of the faulting access |

## Verification
The properties assume that access kind code 3 never appears on either port. They also assume that reset is held for at least one edge with `rf_valid` low, so that the one-cycle-delayed fault check has a clean history. The bench drives only kinds 0 to 2. It changes inputs only on falling edges, after reset has been released, so every property sees stable, legal requests. The stimulus deliberately includes aliasing slots, a flush in the same cycle as a refill, and an all-ones page number. This keeps the flush and all-ones properties in play inside those assumptions.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    localparam int DEF_ADDR_W     = 64;
    localparam int DEF_PAGE_SHIFT = 12;
    localparam int DEF_ENTRIES    = 16;

    // Bit positions inside a leaf entry
    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_USER_LO   = 2;
    localparam int PTE_SUP_LO    = 5;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    function automatic perm_t perm_from_bits(input logic [2:0] b);
        perm_t p;
        p.rd = b[0];
        p.wr = b[1];
        p.ex = b[2];
        return p;
    endfunction

    // Supervisor triplet is moved onto the user positions when privileged
    function automatic perm_t effective_perm(input logic [7:0] lo, input logic sup);
        return sup ? perm_from_bits(lo[PTE_SUP_LO +: 3])
                   : perm_from_bits(lo[PTE_USER_LO +: 3]);
    endfunction

    function automatic logic perm_allows(input perm_t p, input acc_e k);
        logic ok;
        case (k)
            ACC_FETCH: ok = p.ex;
            ACC_STORE: ok = p.wr;
            default:   ok = p.rd;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
    import dtlb_pkg::*;
(
    input  logic [7:0] pte_lo,
    input  logic       sup,
    input  acc_e       kind,
    output perm_t      grant,
    output logic       allowed
);
    perm_t eff;

    always_comb begin
        eff     = effective_perm(pte_lo, sup);
        grant   = eff;
        allowed = pte_lo[PTE_VALID_BIT] && perm_allows(eff, kind);
    end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import dtlb_pkg::*;
#(
    parameter int ENTRIES = DEF_ENTRIES,
    parameter int VPN_W   = DEF_ADDR_W - DEF_PAGE_SHIFT,
    parameter int PPN_W   = DEF_ADDR_W - DEF_PAGE_SHIFT,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  perm_t            wr_grant,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VPN_W-1:0] rd_tag_ld,
    output logic [VPN_W-1:0] rd_tag_st,
    output logic [VPN_W-1:0] rd_tag_ex,
    output logic [PPN_W-1:0] rd_ppn
);
    localparam logic [VPN_W-1:0] TAG_NONE = '1;

    typedef struct packed {
        logic [VPN_W-1:0] tag_ld;
        logic [VPN_W-1:0] tag_st;
        logic [VPN_W-1:0] tag_ex;
        logic [PPN_W-1:0] ppn;
    } slot_t;

    slot_t [ENTRIES-1:0] slots;

    genvar gi;
    generate
        for (gi = 0; gi < ENTRIES; gi++) begin : g_slot
            slot_t cur;
            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    cur.tag_ld <= TAG_NONE;
                    cur.tag_st <= TAG_NONE;
                    cur.tag_ex <= TAG_NONE;
                end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                    cur.tag_ld <= wr_grant.rd ? wr_vpn : TAG_NONE;
                    cur.tag_st <= wr_grant.wr ? wr_vpn : TAG_NONE;
                    cur.tag_ex <= wr_grant.ex ? wr_vpn : TAG_NONE;
                end
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    cur.ppn <= '0;
                end else if (wr_en && !flush && (wr_idx == IDX_W'(gi))) begin
                    cur.ppn <= wr_ppn;
                end
            end
            assign slots[gi] = cur;
        end
    endgenerate

    always_comb begin
        rd_tag_ld = slots[rd_idx].tag_ld;
        rd_tag_st = slots[rd_idx].tag_st;
        rd_tag_ex = slots[rd_idx].tag_ex;
        rd_ppn    = slots[rd_idx].ppn;
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import dtlb_pkg::*;
#(
    parameter int VPN_W = DEF_ADDR_W - DEF_PAGE_SHIFT
) (
    input  logic             req,
    input  acc_e             kind,
    input  logic [VPN_W-1:0] vpn,
    input  logic [VPN_W-1:0] tag_ld,
    input  logic [VPN_W-1:0] tag_st,
    input  logic [VPN_W-1:0] tag_ex,
    output logic             hit
);
    logic [VPN_W-1:0] sel_tag;
    logic             vpn_reserved;

    always_comb begin
        case (kind)
            ACC_FETCH: sel_tag = tag_ex;
            ACC_STORE: sel_tag = tag_st;
            default:   sel_tag = tag_ld;
        endcase
        vpn_reserved = &vpn;
        hit = req && !vpn_reserved && (sel_tag == vpn);
    end
endmodule

// File: rtl/dtlb_split.sv
module dtlb_split
    import dtlb_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int PAGE_SHIFT = DEF_PAGE_SHIFT,
    parameter int ENTRIES    = DEF_ENTRIES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              priv_sup,
    input  logic              lk_valid,
    input  logic [1:0]        lk_kind,
    input  logic [ADDR_W-1:0] lk_vaddr,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [ADDR_W-1:0] lk_paddr,
    input  logic              rf_valid,
    input  logic [1:0]        rf_kind,
    input  logic [ADDR_W-1:0] rf_vaddr,
    input  logic [ADDR_W-1:0] rf_pte,
    output logic              flt_valid,
    output logic [1:0]        flt_kind,
    output logic [ADDR_W-1:0] flt_vaddr
);
    localparam int VPN_W = ADDR_W - PAGE_SHIFT;
    localparam int IDX_W = $clog2(ENTRIES);

    // ---------------- lookup path ----------------
    logic [VPN_W-1:0] lk_vpn;
    logic [VPN_W-1:0] t_ld, t_st, t_ex;
    logic [VPN_W-1:0] hit_ppn;
    logic             match;

    assign lk_vpn = lk_vaddr[ADDR_W-1:PAGE_SHIFT];

    // ---------------- refill path ----------------
    logic [VPN_W-1:0] rf_vpn;
    perm_t            rf_grant;
    logic             rf_ok;
    logic             rf_write;
    logic             unused_pte_bits;

    assign rf_vpn          = rf_vaddr[ADDR_W-1:PAGE_SHIFT];
    assign rf_write        = rf_valid && rf_ok && !flush;
    assign unused_pte_bits = ^{rf_pte[PAGE_SHIFT-1:8], rf_pte[1]};

    tlb_perm_check u_perm (
        .pte_lo  (rf_pte[7:0]),
        .sup     (priv_sup),
        .kind    (acc_e'(rf_kind)),
        .grant   (rf_grant),
        .allowed (rf_ok)
    );

    tlb_entry_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (VPN_W)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .wr_en     (rf_write),
        .wr_idx    (rf_vpn[IDX_W-1:0]),
        .wr_vpn    (rf_vpn),
        .wr_grant  (rf_grant),
        .wr_ppn    (rf_pte[ADDR_W-1:PAGE_SHIFT]),
        .rd_idx    (lk_vpn[IDX_W-1:0]),
        .rd_tag_ld (t_ld),
        .rd_tag_st (t_st),
        .rd_tag_ex (t_ex),
        .rd_ppn    (hit_ppn)
    );

    tlb_match #(.VPN_W(VPN_W)) u_match (
        .req    (lk_valid),
        .kind   (acc_e'(lk_kind)),
        .vpn    (lk_vpn),
        .tag_ld (t_ld),
        .tag_st (t_st),
        .tag_ex (t_ex),
        .hit    (match)
    );

    always_comb begin
        lk_hit   = match;
        lk_miss  = lk_valid && !match;
        lk_paddr = match ? {hit_ppn, lk_vaddr[PAGE_SHIFT-1:0]} : '0;
    end

    // ---------------- fault report ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            flt_valid <= 1'b0;
            flt_kind  <= 2'd0;
            flt_vaddr <= '0;
        end else begin
            flt_valid <= rf_valid && !rf_ok;
            if (rf_valid && !rf_ok) begin
                flt_kind  <= rf_kind;
                flt_vaddr <= rf_vaddr;
            end
        end
    end
endmodule

// File: rtl/dtlb_split_chk.sv
module dtlb_split_chk #(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic              lk_valid,
    input logic [1:0]        lk_kind,
    input logic [ADDR_W-1:0] lk_vaddr,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic [ADDR_W-1:0] lk_paddr,
    input logic              rf_valid,
    input logic [1:0]        rf_kind,
    input logic [ADDR_W-1:0] rf_vaddr,
    input logic              flt_valid,
    input logic [1:0]        flt_kind,
    input logic [ADDR_W-1:0] flt_vaddr
);
    p_flush_clears_r1: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lk_hit);

    p_kind_legal_r3: assert property (@(posedge clk) disable iff (rst)
        (lk_valid |-> lk_kind != 2'd3) and (rf_valid |-> rf_kind != 2'd3));

    p_fault_source_r6: assert property (@(posedge clk) disable iff (rst)
        flt_valid |-> ($past(rf_valid) && flt_vaddr == $past(rf_vaddr)
                       && flt_kind == $past(rf_kind)));

    p_no_fault_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !rf_valid |=> !flt_valid);

    p_hit_offset_r7: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_paddr[PAGE_SHIFT-1:0] == lk_vaddr[PAGE_SHIFT-1:0]);

    p_hit_miss_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_miss));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && !lk_miss && lk_paddr == '0));

    p_reserved_vpn_r10: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && (&lk_vaddr[ADDR_W-1:PAGE_SHIFT])) |-> !lk_hit);
endmodule

bind dtlb_split dtlb_split_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .lk_valid  (lk_valid),
    .lk_kind   (lk_kind),
    .lk_vaddr  (lk_vaddr),
    .lk_hit    (lk_hit),
    .lk_miss   (lk_miss),
    .lk_paddr  (lk_paddr),
    .rf_valid  (rf_valid),
    .rf_kind   (rf_kind),
    .rf_vaddr  (rf_vaddr),
    .flt_valid (flt_valid),
    .flt_kind  (flt_kind),
    .flt_vaddr (flt_vaddr)
);

// File: tb/dtlb_split_tb.sv
`timescale 1ns/1ps
module dtlb_split_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        priv_sup = 1'b0;
    logic        lk_valid = 1'b0;
    logic [1:0]  lk_kind = 2'd0;
    logic [63:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss;
    logic [63:0] lk_paddr;
    logic        rf_valid = 1'b0;
    logic [1:0]  rf_kind = 2'd0;
    logic [63:0] rf_vaddr = '0;
    logic [63:0] rf_pte = '0;
    logic        flt_valid;
    logic [1:0]  flt_kind;
    logic [63:0] flt_vaddr;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    dtlb_split u_dut (
        .clk(clk), .rst(rst), .flush(flush), .priv_sup(priv_sup),
        .lk_valid(lk_valid), .lk_kind(lk_kind), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .rf_valid(rf_valid), .rf_kind(rf_kind), .rf_vaddr(rf_vaddr),
        .rf_pte(rf_pte), .flt_valid(flt_valid), .flt_kind(flt_kind),
        .flt_vaddr(flt_vaddr)
    );

    typedef struct packed {
        logic        is_rf;
        logic [1:0]  kind;
        logic        sup;
        logic [63:0] va;
        logic [63:0] pte;
        logic        exp_hit;
        logic        exp_flt;
        logic [63:0] exp_pa;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        // R4: user read-only page in slot 2
        '{1'b1, 2'd0, 1'b0, 64'h42ABC, 64'h8000_0005, 1'b0, 1'b0, 64'h0},
        '{1'b0, 2'd0, 1'b0, 64'h42ABC, 64'h0, 1'b1, 1'b0, 64'h8000_0ABC},
        '{1'b0, 2'd1, 1'b0, 64'h42ABC, 64'h0, 1'b0, 1'b0, 64'h0},
        '{1'b0, 2'd2, 1'b0, 64'h42ABC, 64'h0, 1'b0, 1'b0, 64'h0},
        // R6: store refill on read-only page faults, slot unchanged
        '{1'b1, 2'd1, 1'b0, 64'h42ABC, 64'h8000_0005, 1'b0, 1'b1, 64'h0},
        '{1'b0, 2'd0, 1'b0, 64'h42ABC, 64'h0, 1'b1, 1'b0, 64'h8000_0ABC},
        // R2: aliasing page 0x52 evicts page 0x42
        '{1'b1, 2'd2, 1'b0, 64'h52010, 64'h9000_001D, 1'b0, 1'b0, 64'h0},
        '{1'b0, 2'd0, 1'b0, 64'h42ABC, 64'h0, 1'b0, 1'b0, 64'h0},
        '{1'b0, 2'd1, 1'b0, 64'h52FFF, 64'h0, 1'b1, 1'b0, 64'h9000_0FFF},
        // R5: supervisor ignores user bits, uses bits 7:5
        '{1'b1, 2'd0, 1'b1, 64'h73000, 64'hA000_001D, 1'b0, 1'b1, 64'h0},
        '{1'b1, 2'd0, 1'b1, 64'h73000, 64'hA000_00E1, 1'b0, 1'b0, 64'h0},
        '{1'b0, 2'd2, 1'b0, 64'h73456, 64'h0, 1'b1, 1'b0, 64'hA000_0456},
        '{1'b1, 2'd1, 1'b0, 64'h73000, 64'hA000_00E1, 1'b0, 1'b1, 64'h0},
        // R6: valid bit clear faults
        '{1'b1, 2'd0, 1'b0, 64'h14000, 64'hB000_0004, 1'b0, 1'b1, 64'h0},
        '{1'b0, 2'd0, 1'b0, 64'h14000, 64'h0, 1'b0, 1'b0, 64'h0},
        // R7: high addresses, write-only page
        '{1'b1, 2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_E008, 64'h1234_5678_9000_0009, 1'b0, 1'b0, 64'h0},
        '{1'b0, 2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_E777, 64'h0, 1'b1, 1'b0, 64'h1234_5678_9000_0777},
        '{1'b0, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_E777, 64'h0, 1'b0, 1'b0, 64'h0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [1:0] k, input logic [63:0] va,
                          input logic eh, input logic [63:0] epa, input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_kind  = k;
        lk_vaddr = va;
        #1;
        chk({req, " hit"}, 64'(lk_hit), 64'(eh));
        chk({req, " miss"}, 64'(lk_miss), 64'(!eh));
        chk({req, " paddr"}, lk_paddr, epa);
        lk_valid = 1'b0;
    endtask

    task automatic refill(input logic [1:0] k, input logic sup, input logic [63:0] va,
                          input logic [63:0] pte, input logic ef, input logic with_flush,
                          input string req);
        @(negedge clk);
        rf_valid = 1'b1;
        rf_kind  = k;
        rf_vaddr = va;
        rf_pte   = pte;
        priv_sup = sup;
        flush    = with_flush;
        @(negedge clk);
        rf_valid = 1'b0;
        flush    = 1'b0;
        #1;
        chk({req, " flt_valid"}, 64'(flt_valid), 64'(ef));
        if (ef) begin
            chk({req, " flt_vaddr"}, flt_vaddr, va);
            chk({req, " flt_kind"}, 64'(flt_kind), 64'(k));
        end
        @(negedge clk);
        #1;
        chk({req, " fault pulse ends"}, 64'(flt_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R8: reset state
        #1;
        chk("R8 idle hit", 64'(lk_hit), 64'd0);
        chk("R8 idle miss", 64'(lk_miss), 64'd0);
        chk("R6 no fault after reset", 64'(flt_valid), 64'd0);
        lookup(2'd0, 64'h42ABC, 1'b0, 64'h0, "R1 reset miss");
        lookup(2'd1, 64'h0, 1'b0, 64'h0, "R1 reset miss page 0");

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_rf)
                refill(VEC[i].kind, VEC[i].sup, VEC[i].va, VEC[i].pte,
                       VEC[i].exp_flt, 1'b0, $sformatf("R6 vec%0d", i));
            else
                lookup(VEC[i].kind, VEC[i].va, VEC[i].exp_hit, VEC[i].exp_pa,
                       $sformatf("R3 vec%0d", i));
        end

        // R1: flush invalidates every slot
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        lookup(2'd1, 64'h52FFF, 1'b0, 64'h0, "R1 flush slot2");
        lookup(2'd2, 64'h73456, 1'b0, 64'h0, "R1 flush slot3");
        lookup(2'd1, 64'hFFFF_FFFF_FFFF_E777, 1'b0, 64'h0, "R1 flush slotE");

        // R9: flush beats refill in same cycle
        refill(2'd0, 1'b0, 64'h66000, 64'hC000_001D, 1'b0, 1'b1, "R9 flush+refill");
        lookup(2'd0, 64'h66000, 1'b0, 64'h0, "R9 refill dropped");
        refill(2'd0, 1'b0, 64'h66000, 64'hC000_001D, 1'b0, 1'b0, "R9 refill alone");
        lookup(2'd2, 64'h66123, 1'b1, 64'hC000_0123, "R9 refill written");

        // R10: all-ones page number never hits
        lookup(2'd0, 64'hFFFF_FFFF_FFFF_F000, 1'b0, 64'h0, "R10 fresh");
        refill(2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_F000, 64'h7000_0005, 1'b0, 1'b0, "R10 refill");
        lookup(2'd0, 64'hFFFF_FFFF_FFFF_F010, 1'b0, 64'h0, "R10 after refill");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule